// File: doc/BRIEF.md
# UART/IR Transmit Line Front End

This block is the last stage of a serial transmitter. It takes bytes over a valid/ready stream, wraps each one in a character frame and drives one of two pins. The frame is a low start bit, the data bits least significant first, an optional parity bit and a high stop bit. In wired mode the frame goes out unchanged on the wired TX pin. In the infrared modes every zero symbol becomes activity on the IR TX pin. In SIR mode that activity is a short pulse at the start of the bit. In Sharp-IR mode it is either an internally generated carrier or a solid high level. A one-deep holding register lets the next character wait while the current one is shifting, so consecutive frames leave no idle gap.

The break control overrides only the pins. While break is set the wired pin is held low in wired mode. In SIR mode, and in Sharp-IR mode with the carrier enabled, the IR pin emits a zero symbol in every bit period. In Sharp-IR mode without the carrier the IR pin is held high. The framer keeps shifting during break, so software can time the break length by sending dummy characters and watching the empty flag. Timing is driven by `os_tick`, a strobe at `SUB_PER_BIT` times the bit rate. One bit lasts `SUB_PER_BIT` ticks.

Back-pressure works as follows. A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low while a character is held waiting for the shifter. Once the byte has moved into the shifter, `in_ready` goes high again at the next bit boundary. The source must keep `in_valid` and `in_data` steady until it is accepted.

Top module: `irtx_line_front`

## Requirements
- R1: The frame on the wired pin is a 0 start bit, then the DATA_W data bits LSB first, then a 1 stop bit; the pin idles at 1.
- R2: With `par_en`=0 no parity bit is sent and `par_stick`/`par_even` have no effect; a waiting character's start bit directly follows the previous stop bit.
- R3: With `par_en`=1 and `par_stick`=0, a parity bit is sent between the data and stop bits: `par_even`=1 makes the count of ones in the data plus parity even, `par_even`=0 makes it odd.
- R4: With `par_en`=1 and `par_stick`=1, the parity bit is 0 when `par_even`=1 and 1 when `par_even`=0.
- R5: A byte is accepted on a clock edge with `in_valid` and `in_ready` high; `in_ready` is low from the cycle after acceptance until the held byte enters the shifter, which happens only when the previous frame has finished.
- R6: `tx_empty` is 1 exactly when no character is held or shifting; it is 0 from the cycle after an acceptance.
- R7: Mode encoding `mode`: 0 = wired UART, 1 = SIR, 2 = Sharp-IR, 3 = treated as wired UART. In wired mode with `brk`=1 the wired pin is 0 one cycle later, while the framer still shifts and `tx_empty` still returns to 1 after the frame time.
- R8: In SIR mode each 0 symbol is a high pulse on `ir_tx` for the first PULSE_SUBS sub-bit ticks of the bit and a 1 symbol gives no pulse; in both IR modes the wired pin stays 1.
- R9: In SIR mode with `brk`=1, `ir_tx` emits a PULSE_SUBS-tick pulse in every bit period.
- R10: In Sharp-IR mode with `sharp_mod_en`=1, a 0 symbol and the break state drive a carrier on `ir_tx` that is high on every odd sub-bit tick.
- R11: In Sharp-IR mode with `sharp_mod_en`=0, a 0 symbol drives `ir_tx` high for the whole bit, and `brk`=1 holds `ir_tx` at 1.
- R12: In wired mode `ir_tx` stays 0; after reset `tx_wire`=1, `ir_tx`=0, `in_ready`=1, `tx_empty`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Sub-bit strobe, SUB_PER_BIT per bit |
| in_data | input | DATA_W | Byte to send |
| in_valid | input | 1 | Source offers `in_data` |
| in_ready | output | 1 | Block can take a byte |
| mode | input | 2 | Line mode select |
| sharp_mod_en | input | 1 | Internal carrier for Sharp-IR |
| par_en | input | 1 | Append parity bit |
| par_stick | input | 1 | Fixed-value parity |
| par_even | input | 1 | Even parity / stick value select |
| brk | input | 1 | Break on the output pins |
| tx_wire | output | 1 | Wired serial output |
| ir_tx | output | 1 | Infrared output |
| tx_empty | output | 1 | Nothing held or shifting |

## Verification
The bench uses the defaults DATA_W=8, SUB_PER_BIT=16 and PULSE_SUBS=3, and keeps `os_tick` high on every clock, so one bit lasts exactly 16 clocks. With that timing the wired pin can be sampled mid-bit, and the IR activity can be counted exactly: 3 high clocks per SIR zero, 8 per carrier zero, 16 per unmodulated zero. Break windows of 160 clocks cover exactly ten bit periods, whatever their phase.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  typedef enum logic [1:0] {
    LM_WIRE  = 2'd0,
    LM_SIR   = 2'd1,
    LM_SHARP = 2'd2,
    LM_WIRE2 = 2'd3
  } line_mode_e;
endpackage

// File: rtl/irtx_subphase.sv
module irtx_subphase #(
  parameter int SUB_PER_BIT = 16,
  parameter int PULSE_SUBS  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick,
  output logic bit_end,
  output logic pulse_win,
  output logic carrier
);
  localparam int PHW = (SUB_PER_BIT > 1) ? $clog2(SUB_PER_BIT) : 1;
  localparam logic [PHW-1:0] LAST = PHW'(SUB_PER_BIT - 1);
  localparam logic [PHW-1:0] PLIM = PHW'(PULSE_SUBS);

  logic [PHW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else if (os_tick) phase <= (phase == LAST) ? '0 : phase + 1'b1;
  end

  assign bit_end   = os_tick && (phase == LAST);
  assign pulse_win = phase < PLIM;
  assign carrier   = phase[0];
endmodule

// File: rtl/irtx_framer.sv
module irtx_framer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_end,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              par_en,
  input  logic              par_stick,
  input  logic              par_even,
  output logic              line_bit,
  output logic              empty
);
  localparam int FW = DATA_W + 3;
  localparam int CW = $clog2(FW + 1);

  logic              pend, active, par_bit;
  logic [DATA_W-1:0] hold;
  logic [FW-1:0]     shreg, frame_word;
  logic [CW-1:0]     cnt;

  always_comb begin
    unique case ({par_stick, par_even})
      2'b01:   par_bit = ^hold;
      2'b00:   par_bit = ~^hold;
      2'b11:   par_bit = 1'b0;
      default: par_bit = 1'b1;
    endcase
    frame_word = {1'b1, (par_en ? par_bit : 1'b1), hold, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      active <= 1'b0;
      hold   <= '0;
      shreg  <= '1;
      cnt    <= '0;
    end else begin
      if (in_valid && !pend) begin
        pend <= 1'b1;
        hold <= in_data;
      end
      if (bit_end) begin
        if (active && cnt > CW'(1)) begin
          shreg <= {1'b1, shreg[FW-1:1]};
          cnt   <= cnt - 1'b1;
        end else if (pend) begin
          shreg  <= frame_word;
          cnt    <= par_en ? CW'(FW) : CW'(FW - 1);
          active <= 1'b1;
          pend   <= 1'b0;
        end else begin
          active <= 1'b0;
        end
      end
    end
  end

  assign in_ready = !pend;
  assign line_bit = active ? shreg[0] : 1'b1;
  assign empty    = !pend && !active;
endmodule

// File: rtl/irtx_pin_stage.sv
module irtx_pin_stage
  import irtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       sharp_mod_en,
  input  logic       brk,
  input  logic       line_bit,
  input  logic       pulse_win,
  input  logic       carrier,
  output logic       tx_wire,
  output logic       ir_tx
);
  logic sym_on, nxt_wire, nxt_ir;

  always_comb begin
    sym_on   = brk | ~line_bit;
    nxt_wire = 1'b1;
    nxt_ir   = 1'b0;
    unique case (line_mode_e'(mode))
      LM_SIR:   nxt_ir = sym_on & pulse_win;
      LM_SHARP: nxt_ir = sharp_mod_en ? (sym_on & carrier) : sym_on;
      default:  nxt_wire = line_bit & ~brk;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wire <= 1'b1;
      ir_tx   <= 1'b0;
    end else begin
      tx_wire <= nxt_wire;
      ir_tx   <= nxt_ir;
    end
  end
endmodule

// File: rtl/irtx_line_front.sv
module irtx_line_front #(
  parameter int DATA_W      = 8,
  parameter int SUB_PER_BIT = 16,
  parameter int PULSE_SUBS  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        mode,
  input  logic              sharp_mod_en,
  input  logic              par_en,
  input  logic              par_stick,
  input  logic              par_even,
  input  logic              brk,
  output logic              tx_wire,
  output logic              ir_tx,
  output logic              tx_empty
);
  logic bit_end, pulse_win, carrier, line_bit;

  irtx_subphase #(.SUB_PER_BIT(SUB_PER_BIT), .PULSE_SUBS(PULSE_SUBS)) u_phase (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
    .bit_end(bit_end), .pulse_win(pulse_win), .carrier(carrier)
  );

  irtx_framer #(.DATA_W(DATA_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .bit_end(bit_end),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .par_en(par_en), .par_stick(par_stick), .par_even(par_even),
    .line_bit(line_bit), .empty(tx_empty)
  );

  irtx_pin_stage u_pins (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sharp_mod_en(sharp_mod_en),
    .brk(brk), .line_bit(line_bit), .pulse_win(pulse_win), .carrier(carrier),
    .tx_wire(tx_wire), .ir_tx(ir_tx)
  );
endmodule

// File: rtl/irtx_line_chk.sv
module irtx_line_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] mode,
  input logic       sharp_mod_en,
  input logic       brk,
  input logic       tx_wire,
  input logic       ir_tx,
  input logic       tx_empty
);
  // R7
  brk_wire_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && mode == 2'd0) |=> !tx_wire);
  // R11
  sharp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && mode == 2'd2 && !sharp_mod_en) |=> ir_tx);
  // R12
  ir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |=> !ir_tx);
  // R8
  wire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 || mode == 2'd2) |=> tx_wire);
  // R6
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> in_ready);
  // R5
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!tx_empty && !in_ready));
endmodule

bind irtx_line_front irtx_line_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .mode(mode), .sharp_mod_en(sharp_mod_en), .brk(brk),
  .tx_wire(tx_wire), .ir_tx(ir_tx), .tx_empty(tx_empty)
);

// File: tb/sim_irtx_line_front.sv
`timescale 1ns/1ps
module sim_irtx_line_front;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] mode = 2'd0;
  logic       sharp_mod_en = 1'b0;
  logic       par_en = 1'b0, par_stick = 1'b0, par_even = 1'b0, brk = 1'b0;
  logic       tx_wire, ir_tx, tx_empty;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  irtx_line_front u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .mode(mode),
    .sharp_mod_en(sharp_mod_en), .par_en(par_en), .par_stick(par_stick),
    .par_even(par_even), .brk(brk), .tx_wire(tx_wire), .ir_tx(ir_tx),
    .tx_empty(tx_empty)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_data = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic grab(input int n, output logic [31:0] bits);
    bits = '0;
    @(negedge clk);
    while (tx_wire !== 1'b0) @(negedge clk);
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bits[i] = tx_wire;
      if (i < n - 1) repeat (16) @(negedge clk);
    end
  endtask

  function automatic logic [31:0] frame(input logic [7:0] b, input bit pe,
                                        input bit st, input bit ev);
    logic p;
    if (st) p = ev ? 1'b0 : 1'b1;
    else    p = ev ? logic'($countones(b) % 2) : logic'(($countones(b) + 1) % 2);
    return pe ? {21'd0, 1'b1, p, b, 1'b0} : {22'd0, 1'b1, b, 1'b0};
  endfunction

  task automatic wait_empty();
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(tx_wire == 1'b1, "R12 reset tx_wire", tx_wire, 1);
    chk(ir_tx == 1'b0, "R12 reset ir_tx", ir_tx, 0);
    chk(in_ready == 1'b1, "R12 reset in_ready", in_ready, 1);
    chk(tx_empty == 1'b1, "R12 reset tx_empty", tx_empty, 1);
  endtask

  task automatic t_uart(input logic [7:0] b, input bit pe, input bit st,
                        input bit ev, input string req);
    logic [31:0] got;
    logic [31:0] exp;
    wait_empty();
    mode = 2'd0; par_en = pe; par_stick = st; par_even = ev;
    exp = frame(b, pe, st, ev);
    fork
      send(b);
      grab(pe ? 11 : 10, got);
    join
    chk(got == exp, req, got, exp);
  endtask

  task automatic t_b2b();
    logic [31:0] got;
    logic [31:0] exp;
    int lowc;
    wait_empty();
    mode = 2'd0; par_en = 1'b0; par_stick = 1'b1; par_even = 1'b0;
    exp = {frame(8'h3C, 0, 0, 0)[9:0], frame(8'hA5, 0, 0, 0)[9:0]};
    lowc = 0;
    fork
      begin
        send(8'hA5);
        chk(in_ready == 1'b0, "R5 ready low after accept", in_ready, 0);
        chk(tx_empty == 1'b0, "R6 empty low after accept", tx_empty, 0);
        send(8'h3C);
        while (!in_ready) begin lowc++; @(negedge clk); end
      end
      grab(20, got);
    join
    chk(got == exp, "R2 no parity bit, back-to-back frames", got, exp);
    chk(lowc > 100, "R5 held byte waits for shifter", lowc, 101);
  endtask

  task automatic t_uart_break();
    int busy;
    int highs;
    wait_empty();
    mode = 2'd0; par_en = 1'b0; brk = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx_wire == 1'b0, "R7 break forces wire low", tx_wire, 0);
    send(8'h00);
    busy = 0; highs = 0;
    while (!tx_empty && busy < 400) begin
      if (tx_wire) highs++;
      busy++;
      @(negedge clk);
    end
    chk(highs == 0, "R7 wire stays low during break", highs, 0);
    chk(busy >= 150 && busy <= 180, "R7 shifter runs during break", busy, 160);
    brk = 1'b0;
    repeat (2) @(negedge clk);
    chk(tx_wire == 1'b1, "R7 wire restored after break", tx_wire, 1);
  endtask

  task automatic t_ir_frame(input logic [1:0] md, input bit me, input logic [7:0] b,
                            input int exp, input string req);
    int hi;
    int wl;
    wait_empty();
    mode = md; sharp_mod_en = me; par_en = 1'b0;
    repeat (2) @(negedge clk);
    send(b);
    hi = 0; wl = 0;
    while (!tx_empty) begin
      if (ir_tx) hi++;
      if (!tx_wire) wl++;
      @(negedge clk);
    end
    repeat (4) begin
      if (ir_tx) hi++;
      @(negedge clk);
    end
    chk(hi == exp, req, hi, exp);
    if (md != 2'd0) chk(wl == 0, "R8 wire idle in IR mode", wl, 0);
  endtask

  task automatic t_ir_break(input logic [1:0] md, input bit me, input int exp,
                            input string req);
    int hi;
    wait_empty();
    mode = md; sharp_mod_en = me; brk = 1'b1;
    repeat (3) @(negedge clk);
    hi = 0;
    repeat (160) begin
      if (ir_tx) hi++;
      @(negedge clk);
    end
    chk(hi == exp, req, hi, exp);
    brk = 1'b0;
    repeat (3) @(negedge clk);
    chk(ir_tx == 1'b0, "R9 IR idle after break", ir_tx, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_uart(8'hB2, 0, 0, 0, "R1 basic frame LSB first");
    t_uart(8'h01, 0, 1, 1, "R1 R2 frame with stick/even ignored");
    t_b2b();
    t_uart(8'h5A, 1, 0, 1, "R3 even parity 4 ones");
    t_uart(8'h07, 1, 0, 1, "R3 even parity 3 ones");
    t_uart(8'h5A, 1, 0, 0, "R3 odd parity 4 ones");
    t_uart(8'h07, 1, 1, 1, "R4 stick parity zero");
    t_uart(8'h00, 1, 1, 0, "R4 stick parity one");
    t_uart_break();
    t_ir_frame(2'd0, 0, 8'h00, 0,  "R12 IR quiet in wired mode");
    t_ir_frame(2'd1, 0, 8'h5A, 15, "R8 SIR pulse count");
    t_ir_frame(2'd1, 0, 8'hFF, 3,  "R8 SIR only start pulse");
    t_ir_frame(2'd2, 1, 8'h0F, 40, "R10 carrier on zero symbols");
    t_ir_frame(2'd2, 0, 8'h0F, 80, "R11 solid level on zero symbols");
    t_ir_break(2'd1, 0, 30,  "R9 SIR break pulse per bit");
    t_ir_break(2'd2, 1, 80,  "R10 carrier during break");
    t_ir_break(2'd2, 0, 160, "R11 IR held high during break");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule